// File: doc/BRIEF.md
# Receive Error Status and Receiver Enable Control

This unit keeps the sticky receive error flags of a serial port together with its receiver-enable bit. The receiver pulses one line for each detected parity error, framing error or overrun (receive side or transmit side). Each pulse passes only when its enable bit is set in the configuration word that the control logic supplies. A passed pulse sets a flag, and the flag stays set until software clears it.

Software reads the flags through a read-only state word. It changes state only through a separate write-only action word. Each bit of the action word performs one action: it sets or clears the receiver enable, or it clears one error flag. A driver can therefore clear a single flag without a read-modify-write, and without racing against new errors. One interrupt line stays high while any flag is set.

The host port is a single-cycle register port. `host_sel_i` picks the word: 0 is the state word and 1 is the action word. Writes take effect on the next rising clock edge, and reads are combinational.

Top module: `rx_err_status`

## Requirements
- R1: After reset all three error flags are 0, `rx_en_o` is 0, `err_irq_o` is 0, and the state word reads 0.
- R2: A `par_err_i` pulse while `cfg_i[18]` is 1 sets the parity flag, which reads as bit 16 of the state word from the next cycle on and stays set until cleared.
- R3: A `frm_err_i` pulse while `cfg_i[17]` is 1 sets the framing flag, which reads as bit 17 of the state word and is sticky.
- R4: The overrun flag, state bit 19, is set by `ovr_rx_i` while `cfg_i[19]` is 1 or by `ovr_tx_i` while `cfg_i[20]` is 1. It is set independently of the other flags, and any combination of the three flags can be set in the same cycle.
- R5: An error pulse whose enable bit is 0 leaves every flag unchanged.
- R6: A write of the action word clears the parity flag when bit 2 is 1, the framing flag when bit 3 is 1 and the overrun flag when bit 5 is 1. Every other bit of the action word leaves the flags unchanged.
- R7: When an enabled error pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R8: In an action-word write, bit 1 sets `rx_en_o` and bit 0 clears it. When both bits are 1, or neither is, `rx_en_o` keeps its value.
- R9: `err_irq_o` is 1 exactly while at least one error flag is set.
- R10: With `host_sel_i`=0, `host_rdata_o` returns the flags at bits 16, 17 and 19, with all other bits 0. With `host_sel_i`=1 it returns 0. A write with `host_sel_i`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| par_err_i | input | 1 | Parity error pulse from receiver |
| frm_err_i | input | 1 | Framing error pulse from receiver |
| ovr_rx_i | input | 1 | Receive overrun pulse |
| ovr_tx_i | input | 1 | Transmit overrun pulse |
| cfg_i | input | 32 | Configuration word; bits 17..20 enable error capture |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Word select: 0 state, 1 action |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| rx_en_o | output | 1 | Receiver enable |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The assertions assume that the error pulses and the host strobe are synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is released in step with the clock. The bench drives every input on the falling edge, so these conditions hold, and it mixes random pulses, enables and action words with directed cases. The directed cases cover a set and a clear colliding on the same flag, and writes to the state word. Pulses can arrive on consecutive cycles and in any combination, because the design places no spacing rule on them.

// File: rtl/rx_err_status_pkg.sv
package rx_err_status_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_ERR  = 3;
  localparam int unsigned E_PAR  = 0;
  localparam int unsigned E_FRM  = 1;
  localparam int unsigned E_OVR  = 2;

  localparam int unsigned ACT_RXEN_CLR = 0;
  localparam int unsigned ACT_RXEN_SET = 1;

  localparam int unsigned CFG_FRM_EN  = 17;
  localparam int unsigned CFG_PAR_EN  = 18;
  localparam int unsigned CFG_ROVR_EN = 19;
  localparam int unsigned CFG_TOVR_EN = 20;

  localparam bit SEL_STATE  = 1'b0;
  localparam bit SEL_ACTION = 1'b1;

  function automatic int unsigned state_pos(input int unsigned idx);
    case (idx)
      E_PAR:   state_pos = 16;
      E_FRM:   state_pos = 17;
      default: state_pos = 19;
    endcase
  endfunction

  function automatic int unsigned clr_pos(input int unsigned idx);
    case (idx)
      E_PAR:   clr_pos = 2;
      E_FRM:   clr_pos = 3;
      default: clr_pos = 5;
    endcase
  endfunction
endpackage

// File: rtl/rxs_sticky_flag.sv
module rxs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_nxt;

  always_comb begin
    q_nxt = q_q;
    if (clr_i) q_nxt = 1'b0;
    if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_nxt;
  end

  assign q_o = q_q;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rxs_rxen_ctl.sv
module rxs_rxen_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q;
  logic en_nxt;
  logic upd;

  always_comb begin
    upd    = set_i ^ clr_i;
    en_nxt = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= 1'b0;
    else if (upd) en_q <= en_nxt;
  end

  assign en_o = en_q;

  p_rxen_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> en_o);
  p_rxen_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !en_o);
  p_rxen_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == clr_i) |=> $stable(en_o));
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              ovr_rx_i,
  input  logic              ovr_tx_i,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic              host_wr_i,
  input  logic              host_sel_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              rx_en_o,
  output logic              err_irq_o
);
  logic             act_wr;
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_clr;
  logic [N_ERR-1:0] err_q;

  always_comb begin
    act_wr         = host_wr_i && (host_sel_i == SEL_ACTION);
    err_set[E_PAR] = par_err_i && cfg_i[CFG_PAR_EN];
    err_set[E_FRM] = frm_err_i && cfg_i[CFG_FRM_EN];
    err_set[E_OVR] = (ovr_rx_i && cfg_i[CFG_ROVR_EN]) ||
                     (ovr_tx_i && cfg_i[CFG_TOVR_EN]);
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_flag
    assign err_clr[g] = act_wr && host_wdata_i[clr_pos(g)];
    rxs_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_set[g]),
      .clr_i (err_clr[g]),
      .q_o   (err_q[g])
    );
  end

  rxs_rxen_ctl u_rxen (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (act_wr && host_wdata_i[ACT_RXEN_SET]),
    .clr_i (act_wr && host_wdata_i[ACT_RXEN_CLR]),
    .en_o  (rx_en_o)
  );

  always_comb begin
    host_rdata_o = '0;
    if (host_sel_i == SEL_STATE) begin
      for (int i = 0; i < N_ERR; i++) host_rdata_o[state_pos(i)] = err_q[i];
    end
  end

  assign err_irq_o = |err_q;

  p_state_wr_noeffect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && host_sel_i == SEL_STATE && !par_err_i && !frm_err_i &&
     !ovr_rx_i && !ovr_tx_i) |=> ($stable(err_q) && $stable(rx_en_o)));
  p_action_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel_i == SEL_ACTION) |-> (host_rdata_o == '0));
  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel_i == SEL_STATE) |-> (err_irq_o == (host_rdata_o != '0)));
  p_disabled_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i[CFG_ROVR_EN] && !cfg_i[CFG_TOVR_EN] && !err_q[E_OVR]) |=>
      !err_q[E_OVR] || $past(ovr_rx_i && cfg_i[CFG_ROVR_EN]));
endmodule

// File: tb/rx_err_status_tb.sv
module rx_err_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        par_err_i, frm_err_i, ovr_rx_i, ovr_tx_i;
  logic [31:0] cfg_i;
  logic        host_wr_i, host_sel_i;
  logic [31:0] host_wdata_i;
  logic [31:0] host_rdata_o;
  logic        rx_en_o, err_irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit m_par, m_frm, m_ovr, m_en;
  bit x_par, x_frm, x_ovr, x_en;
  string phase = "R1";

  always #5 clk = ~clk;

  rx_err_status u_dut (
    .clk(clk), .rst_n(rst_n), .par_err_i(par_err_i), .frm_err_i(frm_err_i),
    .ovr_rx_i(ovr_rx_i), .ovr_tx_i(ovr_tx_i), .cfg_i(cfg_i),
    .host_wr_i(host_wr_i), .host_sel_i(host_sel_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .rx_en_o(rx_en_o), .err_irq_o(err_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] st;
    st = '0;
    st[16] = m_par; st[17] = m_frm; st[19] = m_ovr;
    check("R2", {31'd0, host_rdata_o[16] & ~host_sel_i}, {31'd0, m_par & ~host_sel_i});
    check("R3", {31'd0, host_rdata_o[17] & ~host_sel_i}, {31'd0, m_frm & ~host_sel_i});
    check("R4", {31'd0, host_rdata_o[19] & ~host_sel_i}, {31'd0, m_ovr & ~host_sel_i});
    check("R8", {31'd0, rx_en_o}, {31'd0, m_en});
    check("R9", {31'd0, err_irq_o}, {31'd0, m_par | m_frm | m_ovr});
    check("R10", host_rdata_o, host_sel_i ? 32'd0 : st);
  endtask

  // Applies one cycle of inputs: compares current outputs, drives, predicts.
  task automatic step(input bit p, input bit f, input bit orx, input bit otx,
                      input logic [31:0] cfg, input bit wr, input bit sel,
                      input logic [31:0] wd);
    @(negedge clk);
    m_par = x_par; m_frm = x_frm; m_ovr = x_ovr; m_en = x_en;
    compare_all();
    par_err_i = p; frm_err_i = f; ovr_rx_i = orx; ovr_tx_i = otx;
    cfg_i = cfg; host_wr_i = wr; host_sel_i = sel; host_wdata_i = wd;
    begin
      bit act;
      act = wr && sel;
      if (act && wd[2]) x_par = 0;
      if (act && wd[3]) x_frm = 0;
      if (act && wd[5]) x_ovr = 0;
      if (p && cfg[18]) x_par = 1;
      if (f && cfg[17]) x_frm = 1;
      if ((orx && cfg[19]) || (otx && cfg[20])) x_ovr = 1;
      if (act && (wd[1] != wd[0])) x_en = wd[1];
    end
  endtask

  localparam logic [31:0] ALL_EN = 32'h001E_0000;

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    par_err_i = 0; frm_err_i = 0; ovr_rx_i = 0; ovr_tx_i = 0;
    cfg_i = '0; host_wr_i = 0; host_sel_i = 0; host_wdata_i = '0;
    {x_par, x_frm, x_ovr, x_en} = '0;
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", host_rdata_o, 32'd0);
    check("R1", {30'd0, rx_en_o, err_irq_o}, 32'd0);
    rst_n = 1'b1;
    step(0,0,0,0, 0, 0,0, 0);
    // R5: pulses with enables off do nothing
    phase = "R5";
    step(1,1,1,1, 32'h0000_0000, 0,0, 0);
    step(1,1,1,1, ~ALL_EN, 0,0, 0);
    step(0,0,0,0, 0, 0,0, 0);
    // R2/R3/R4 individually
    phase = "R2";
    step(1,0,0,0, ALL_EN, 0,0, 0);
    step(0,0,0,0, 0, 0,0, 0);
    phase = "R3";
    step(0,1,0,0, 32'h0002_0000, 0,0, 0);
    step(0,0,0,0, 0, 0,0, 0);
    phase = "R6";
    step(0,0,0,0, 0, 1,1, 32'h0000_000C);
    step(0,0,0,0, 0, 0,0, 0);
    phase = "R4";
    step(0,0,0,1, 32'h0010_0000, 0,0, 0);
    step(0,0,0,0, 0, 1,1, 32'hFFFF_FFD3);
    step(0,0,0,0, 0, 1,1, 32'h0000_0020);
    step(0,0,1,0, 32'h0008_0000, 0,0, 0);
    step(1,1,1,0, ALL_EN, 0,0, 0);
    step(0,0,0,0, 0, 0,0, 0);
    // R10: state word write ignored
    phase = "R10";
    step(0,0,0,0, 0, 1,0, 32'hFFFF_FFFF);
    step(0,0,0,0, 0, 0,1, 0);
    // R7: set wins over clear
    phase = "R7";
    step(1,1,1,0, ALL_EN, 1,1, 32'h0000_002C);
    step(0,0,0,0, 0, 0,0, 0);
    // R8: receiver enable
    phase = "R8";
    step(0,0,0,0, 0, 1,1, 32'h2);
    step(0,0,0,0, 0, 1,1, 32'h3);
    step(0,0,0,0, 0, 1,1, 32'h0);
    step(0,0,0,0, 0, 1,1, 32'h1);
    step(0,0,0,0, 0, 1,1, 32'h3);
    step(0,0,0,0, 0, 0,0, 0);
    // random mix
    phase = "random";
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2], r[3], {11'd0, r[8:5], 17'd0}, r[9], r[10],
           {26'd0, r[16:11]});
    end
    step(0,0,0,0, 0, 0,0, 0);
    step(0,0,0,0, 0, 0,0, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule